// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Receive Queue

This block is the receive half of a register-mapped serial port. It watches a single serial line, runs a 16x oversampling tick, and turns each asynchronous character into an 11-bit word. The low byte holds the data, right-aligned. Three tag bits sit beside it and record framing, parity and break conditions. Words collect in a 16-entry queue, which the bus side drains through a valid/ready pop port. Clear-on-pulse control, a fill threshold, a sticky overrun flag and an idle timeout give software what it needs to manage the queue.

Software sets the character shape: 5 to 8 data bits, optional parity (even or odd), and one stop bit. It also chooses the line source, either the external pin or a loopback copy of the local transmitter output. The pop port follows valid/ready rules. `out_valid` is high whenever the queue holds a word, and `out_word` shows the oldest entry. A word leaves the queue on every rising clock edge where both `out_valid` and `out_ready` are high. Holding `out_ready` low stalls the drain for as long as needed. The serial line cannot be stalled, so while the queue is full, newly arriving characters are discarded.

Top module: `serial_rx_tagged`

## Requirements
- R1: With `len_code` = n, each character carries 5+n data bits, sent least significant bit first. The data appears in `out_word[7:0]` right-aligned, and the unused high bits read as 0.
- R2: A falling line seen on an oversample tick starts a character only if the line is still low on the 8th tick after it. A shorter low pulse produces no word.
- R3: When `par_en` is 1, one parity bit follows the data. `out_word[9]` is set when the data plus parity hold an odd count of ones while `par_even` is 1, or an even count while `par_even` is 0. When `par_en` is 0, no parity bit is expected and bit 9 is 0.
- R4: `out_word[8]` is set when the stop bit samples low. `out_word[10]` is set when every data bit, the parity bit (if enabled) and the stop bit all sample low.
- R5: The queue holds up to 16 words and releases them in arrival order. A word leaves on each clock edge where `out_valid` and `out_ready` are both high. `not_empty` equals `out_valid`.
- R6: A character that completes while 16 words are held is dropped and sets `overrun`. `overrun` stays set through pops and clears only on `fifo_flush`.
- R7: A one-cycle `fifo_flush` pulse empties the queue, so that `out_valid` is 0 on the next cycle.
- R8: While `rx_en` is 0, no character is received and nothing enters the queue.
- R9: When `lb_en` is 1, the receiver decodes `lb_tx` and ignores `rx_pin`. When `lb_en` is 0, it decodes `rx_pin`.
- R10: `fill_hit` is 1 when the queue holds at least `thresh` words and at least one word.
- R11: `idle_timeout` rises once the queue has been non-empty, with the receiver idle and no push or pop, for `idle_limit` bit times (16 ticks each). It clears on a push, a pop, a flush or an empty queue. An `idle_limit` of 0 disables it.
- R12: After reset, `out_valid`, `not_empty`, `overrun`, `fill_hit` and `idle_timeout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_pin | input | 1 | External serial line, idle high |
| lb_tx | input | 1 | Local transmitter output, used in loopback |
| rx_en | input | 1 | Receiver enable |
| lb_en | input | 1 | Selects `lb_tx` as the line source |
| par_en | input | 1 | A parity bit is present |
| par_even | input | 1 | 1 selects even parity, 0 selects odd |
| len_code | input | 2 | Data length code; 5+code bits |
| idle_limit | input | 5 | Idle timeout in bit times; 0 disables |
| thresh | input | 4 | Fill threshold |
| fifo_flush | input | 1 | Pulse that empties the queue and clears overrun |
| out_valid | output | 1 | Head word available |
| out_ready | input | 1 | Consumer accepts the head word |
| out_word | output | 11 | {break, parity error, framing error, data[7:0]} |
| not_empty | output | 1 | Queue holds at least one word |
| overrun | output | 1 | Sticky flag: a character was dropped |
| fill_hit | output | 1 | Fill level has reached the threshold |
| idle_timeout | output | 1 | Queue has sat idle for the timeout period |

## Verification
The assertions assume that `os_tick` is a single-cycle pulse, that the shape controls stay fixed while a character is in flight, and that `fifo_flush` is a single-cycle pulse. The stimulus changes configuration only between characters, while the line is idle. It produces ticks from a free-running divide-by-4 and holds each serial bit for exactly 16 ticks. Every change of the serial line is made on a falling clock edge, which keeps the mid-bit sample well clear of the bit edges.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_W = 8;
  localparam int WORD_W = DATA_W + 3;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI
  } rx_state_e;

  typedef struct packed {
    logic              brk;
    logic              par_err;
    logic              frm_err;
    logic [DATA_W-1:0] data;
  } rx_word_t;
endpackage

// File: rtl/srx_deframer.sv
module srx_deframer
  import srx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     line,
  input  logic     enable,
  input  logic     par_en,
  input  logic     par_even,
  input  logic [1:0] len_code,
  output logic     push,
  output rx_word_t word,
  output logic     busy
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] HALF = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] FULL = CW'(OVS - 1);

  rx_state_e           state;
  logic [CW-1:0]       tcnt;
  logic [2:0]          bidx;
  logic [DATA_W-1:0]   sr;
  logic                par_acc, par_bad, nonzero;
  logic [2:0]          last_idx;

  assign last_idx = {1'b0, len_code} + 3'd4;
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; tcnt <= '0; bidx <= '0; sr <= '0;
      par_acc <= 1'b0; par_bad <= 1'b0; nonzero <= 1'b0;
      push <= 1'b0; word <= '0;
    end else begin
      push <= 1'b0;
      if (!enable) begin
        state <= S_IDLE;
      end else begin
        unique case (state)
          S_IDLE: if (tick && !line) begin
            state <= S_START; tcnt <= '0;
          end
          S_START: if (tick) begin
            if (tcnt == HALF) begin
              tcnt <= '0;
              if (!line) begin
                state <= S_DATA; bidx <= '0; sr <= '0;
                par_acc <= 1'b0; par_bad <= 1'b0; nonzero <= 1'b0;
              end else begin
                state <= S_IDLE;
              end
            end else tcnt <= tcnt + 1'b1;
          end
          S_DATA: if (tick) begin
            if (tcnt == FULL) begin
              tcnt    <= '0;
              sr      <= {line, sr[DATA_W-1:1]};
              par_acc <= par_acc ^ line;
              nonzero <= nonzero | line;
              if (bidx == last_idx) state <= par_en ? S_PAR : S_STOP;
              else bidx <= bidx + 1'b1;
            end else tcnt <= tcnt + 1'b1;
          end
          S_PAR: if (tick) begin
            if (tcnt == FULL) begin
              tcnt    <= '0;
              par_bad <= par_acc ^ line ^ ~par_even;
              nonzero <= nonzero | line;
              state   <= S_STOP;
            end else tcnt <= tcnt + 1'b1;
          end
          S_STOP: if (tick) begin
            if (tcnt == FULL) begin
              tcnt         <= '0;
              push         <= 1'b1;
              word.data    <= sr >> (2'd3 - len_code);
              word.frm_err <= ~line;
              word.par_err <= par_en & par_bad;
              word.brk     <= ~line & ~nonzero;
              state        <= line ? S_IDLE : S_WAITHI;
            end else tcnt <= tcnt + 1'b1;
          end
          S_WAITHI: if (line) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R1
  push_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);
  // R8
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (state == S_IDLE && !push));
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         flush,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] dout,
  output logic [$clog2(DEPTH):0] count,
  output logic         overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, do_push, do_pop;

  assign full      = (count == CW'(DEPTH));
  assign out_valid = (count != '0);
  assign dout      = mem[rptr];
  assign do_push   = push && !full;
  assign do_pop    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0; overrun <= 1'b0;
    end else if (flush) begin
      wptr <= '0; rptr <= '0; count <= '0; overrun <= 1'b0;
    end else begin
      if (push && full) overrun <= 1'b1;
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && !overrun));
  // R6
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(push && full));
endmodule

// File: rtl/srx_idle_timer.sv
module srx_idle_timer #(
  parameter int OVS   = 16,
  parameter int LIM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             busy,
  input  logic             not_empty,
  input  logic             activity,
  input  logic [LIM_W-1:0] limit,
  output logic             flag
);
  localparam int TW = $clog2(OVS);

  logic [TW-1:0]    tcnt;
  logic [LIM_W-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0; bcnt <= '0; flag <= 1'b0;
    end else if (activity || !not_empty) begin
      tcnt <= '0; bcnt <= '0; flag <= 1'b0;
    end else if (limit != '0 && !flag && !busy && tick) begin
      tcnt <= tcnt + 1'b1;
      if (tcnt == TW'(OVS-1)) begin
        bcnt <= bcnt + 1'b1;
        if (bcnt + 1'b1 == limit) flag <= 1'b1;
      end
    end
  end

  // R11
  timeout_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> not_empty);
endmodule

// File: rtl/serial_rx_tagged.sv
module serial_rx_tagged
  import srx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OVS   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        os_tick,
  input  logic        rx_pin,
  input  logic        lb_tx,
  input  logic        rx_en,
  input  logic        lb_en,
  input  logic        par_en,
  input  logic        par_even,
  input  logic [1:0]  len_code,
  input  logic [4:0]  idle_limit,
  input  logic [3:0]  thresh,
  input  logic        fifo_flush,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [10:0] out_word,
  output logic        not_empty,
  output logic        overrun,
  output logic        fill_hit,
  output logic        idle_timeout
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [1:0]    sync_q;
  logic          line, push, busy;
  rx_word_t      word;
  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], lb_en ? lb_tx : rx_pin};
  end
  assign line = sync_q[1];

  srx_deframer #(.OVS(OVS)) u_deframer (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line), .enable(rx_en),
    .par_en(par_en), .par_even(par_even), .len_code(len_code),
    .push(push), .word(word), .busy(busy)
  );

  srx_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(word), .flush(fifo_flush),
    .out_ready(out_ready), .out_valid(out_valid), .dout(out_word),
    .count(count), .overrun(overrun)
  );

  srx_idle_timer #(.OVS(OVS), .LIM_W(5)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .busy(busy),
    .not_empty(out_valid),
    .activity(push || fifo_flush || (out_valid && out_ready)),
    .limit(idle_limit), .flag(idle_timeout)
  );

  assign not_empty = out_valid;
  assign fill_hit  = (count != '0) && (count >= CW'(thresh));
endmodule

// File: tb/serial_rx_tagged_test.sv
module serial_rx_tagged_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, os_tick = 1'b0, tx_line = 1'b1, lb_mode = 1'b0;
  logic rx_en = 1'b0, par_en = 1'b0, par_even = 1'b1, fifo_flush = 1'b0;
  logic out_ready = 1'b0;
  logic [1:0] len_code = 2'd3;
  logic [4:0] idle_limit = 5'd0;
  logic [3:0] thresh = 4'd4;
  logic out_valid, not_empty, overrun, fill_hit, idle_timeout;
  logic [10:0] out_word;
  logic [1:0] tdiv = 2'd0;

  int checks = 0, fails = 0;
  logic [10:0] expq[$];

  always @(posedge clk) begin
    tdiv    <= tdiv + 2'd1;
    os_tick <= (tdiv == 2'd2);
  end

  serial_rx_tagged uut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
    .rx_pin(lb_mode ? 1'b0 : tx_line), .lb_tx(lb_mode ? tx_line : 1'b1),
    .rx_en(rx_en), .lb_en(lb_mode), .par_en(par_en), .par_even(par_even),
    .len_code(len_code), .idle_limit(idle_limit), .thresh(thresh),
    .fifo_flush(fifo_flush), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .not_empty(not_empty), .overrun(overrun),
    .fill_hit(fill_hit), .idle_timeout(idle_timeout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop and compare each handshake (R5 ordering)
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) check(1'b0, "R5 unexpected word", out_word, 0);
      else begin
        automatic logic [10:0] e = expq.pop_front();
        check(out_word == e, "R5 word order/tags", out_word, e);
      end
    end
  end

  task automatic hold_bit(input logic v);
    tx_line = v;
    repeat (64) @(negedge clk);
  endtask

  // drive one character; pexp selects whether the word is expected
  task automatic send(input logic [7:0] d, input int nb, input bit pbit_on,
                      input logic pbit, input logic stopv, input bit pexp,
                      input logic [10:0] expw);
    if (pexp) expq.push_back(expw);
    hold_bit(1'b0);
    for (int i = 0; i < nb; i++) hold_bit(d[i]);
    if (pbit_on) hold_bit(pbit);
    hold_bit(stopv);
    tx_line = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic drain();
    out_ready = 1'b1;
    for (int i = 0; i < 400 && expq.size() != 0; i++) @(negedge clk);
    check(expq.size() == 0, "R5 drain complete", expq.size(), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!out_valid && !not_empty && !overrun && !fill_hit && !idle_timeout,
          "R12 reset outputs", {out_valid, not_empty, overrun, fill_hit, idle_timeout}, 0);
    rst_n = 1'b1; rx_en = 1'b1; out_ready = 1'b1;
    repeat (20) @(negedge clk);

    // R1 8-bit characters
    send(8'hA5, 8, 0, 0, 1, 1, {3'b000, 8'hA5});
    send(8'h3C, 8, 0, 0, 1, 1, {3'b000, 8'h3C});
    // R1 5-bit character, high bits cleared
    len_code = 2'd0;
    send(8'hF5, 5, 0, 0, 1, 1, {3'b000, 8'h15});
    // R3 7-bit even parity, good then bad
    len_code = 2'd2; par_en = 1'b1; par_even = 1'b1;
    send(8'h53, 7, 1, 0, 1, 1, {3'b000, 8'h53});
    send(8'h53, 7, 1, 1, 1, 1, {3'b010, 8'h53});
    // R3 odd parity good
    par_even = 1'b0;
    send(8'h53, 7, 1, 1, 1, 1, {3'b000, 8'h53});
    // R4 framing error and break
    par_en = 1'b0; len_code = 2'd3;
    send(8'h81, 8, 0, 0, 0, 1, {3'b001, 8'h81});
    send(8'h00, 8, 0, 0, 0, 1, {3'b101, 8'h00});
    drain();

    // R2 short low pulse rejected
    out_ready = 1'b0;
    tx_line = 1'b0; repeat (12) @(negedge clk); tx_line = 1'b1;
    repeat (160) @(negedge clk);
    check(!out_valid, "R2 glitch rejected", out_valid, 0);

    // R8 disabled receiver
    rx_en = 1'b0;
    send(8'h77, 8, 0, 0, 1, 0, '0);
    check(!out_valid, "R8 disabled no word", out_valid, 0);
    rx_en = 1'b1;

    // R9 loopback source, pin held low and ignored
    lb_mode = 1'b1;
    send(8'h5A, 8, 0, 0, 1, 1, {3'b000, 8'h5A});
    check(out_valid, "R9 loopback word received", out_valid, 1);
    drain();
    lb_mode = 1'b0;

    // R10 threshold and R11 timeout
    out_ready = 1'b0; idle_limit = 5'd2;
    send(8'h01, 8, 0, 0, 1, 1, {3'b000, 8'h01});
    send(8'h02, 8, 0, 0, 1, 1, {3'b000, 8'h02});
    send(8'h03, 8, 0, 0, 1, 1, {3'b000, 8'h03});
    check(!fill_hit, "R10 below threshold", fill_hit, 0);
    send(8'h04, 8, 0, 0, 1, 1, {3'b000, 8'h04});
    check(fill_hit, "R10 at threshold", fill_hit, 1);
    check(!idle_timeout, "R11 not yet timed out", idle_timeout, 0);
    repeat (192) @(negedge clk);
    check(idle_timeout, "R11 timeout raised", idle_timeout, 1);
    drain();
    @(negedge clk);
    check(!idle_timeout, "R11 cleared when empty", idle_timeout, 0);
    idle_limit = 5'd0;

    // R6 overrun: 17 characters, the last is dropped
    out_ready = 1'b0;
    for (int k = 0; k < 17; k++)
      send(8'h10 + 8'(k), 8, 0, 0, 1, k < 16, {3'b000, 8'h10 + 8'(k)});
    check(overrun, "R6 overrun set", overrun, 1);
    check(not_empty, "R5 not_empty when full", not_empty, 1);
    drain();
    check(overrun, "R6 overrun sticky after pops", overrun, 1);
    fifo_flush = 1'b1; @(negedge clk); fifo_flush = 1'b0;
    check(!overrun, "R6 overrun cleared by flush", overrun, 0);

    // R7 flush discards held words
    out_ready = 1'b0;
    send(8'hC3, 8, 0, 0, 1, 0, '0);
    send(8'h3C, 8, 0, 0, 1, 0, '0);
    check(out_valid, "R7 words held before flush", out_valid, 1);
    fifo_flush = 1'b1; @(negedge clk); fifo_flush = 1'b0;
    check(!out_valid && !not_empty, "R7 flush empties", out_valid, 0);
    out_ready = 1'b1;
    repeat (20) @(negedge clk);
    check(expq.size() == 0, "R7 nothing after flush", expq.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule